// File: doc/BRIEF.md
# Chip-Select Wait-State Generator

This block stretches external bus cycles for two chip-select regions. A bus cycle starts with a one-clock `acc_start` pulse. With that pulse the block takes the upper address lines and the internal-access flag. It decodes them into chip select 0, chip select 1 or no select, and it holds the result for the whole cycle. When the `t4` phase indicator arrives, the block picks a wait count. For region 0 the count comes from the low data-bus bits if external wait control is enabled, and from a 3-bit register otherwise. Region 1 always uses a 2-bit register. A down-counter then holds the cycle for that many clocks before `rdy` pulses.

A wait-sample strobe can be enabled to mark the T4 clock of region-0 cycles. External logic uses that clock to drive the wait count onto the data lines.

The control is a four-state machine:
- `ST_IDLE` moves to `ST_ADDR` on `acc_start` (the start transition).
- `ST_ADDR` waits for `t4`. On `t4` it moves to `ST_DONE` if the chosen count is zero (the zero-wait transition), or to `ST_HOLD` otherwise (the load transition).
- `ST_HOLD` counts down and moves to `ST_DONE` when the counter reaches its last wait clock (the expiry transition).
- `ST_DONE` drives `rdy` and returns to `ST_IDLE` on the next clock (the release transition).

Top module: `wsg_top`

## Requirements
- R1: Chip select 0 is decoded when `addr_top == {1'b0, cs0_rng}` and chip select 1 when `addr_top == {1'b1, cs1_rng}`. Both selects are active low and are driven low from the clock after `acc_start` until `rdy` has been high for one clock.
- R2: If `int_acc` is high at the start of an access, chip select 0 stays high even when the address is in its region, and the cycle has zero wait states.
- R3: When `cs0_ext` is 1, the region-0 wait count is the value on `wait_dat` in the `t4` clock. A value of 3'b111 gives 7 wait states.
- R4: When `cs0_ext` is 0, the region-0 wait count is `cs0_wait`, and `wait_dat` has no effect.
- R5: The region-1 wait count is `cs1_wait`, from 0 to 3.
- R6: `rdy` is a one-clock pulse that comes exactly N+1 clocks after the `t4` clock, where N is the chosen wait count. With N = 0 it comes in the very next clock.
- R7: In the clock after `rdy`, both chip selects are high.
- R8: `wss_n` is low only in the `t4` clock of a region-0 cycle while `strobe_en` is 1. It is high in every other clock.
- R9: An access that hits neither region completes with zero wait states and leaves `wss_n` high.
- R10: An `acc_start` pulse that arrives while a cycle is in progress is ignored. The selected chip select and the cycle timing do not change.
- R11: After reset, both chip selects and `wss_n` are high and `rdy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_start | input | 1 | One-clock pulse that opens a bus cycle |
| addr_top | input | 3 | Upper address lines used for the region compare |
| int_acc | input | 1 | The access is served internally |
| t4 | input | 1 | High during bus phase T4 of the cycle |
| wait_dat | input | 3 | Low data-bus bits that carry an external wait count |
| cs0_rng | input | 2 | Region-0 range field |
| cs1_rng | input | 2 | Region-1 range field |
| cs0_ext | input | 1 | 1: region-0 count comes from `wait_dat` |
| cs0_wait | input | 3 | Internal region-0 wait count |
| cs1_wait | input | 2 | Region-1 wait count |
| strobe_en | input | 1 | Enables the wait-sample strobe |
| cs0_n | output | 1 | Chip select 0, active low |
| cs1_n | output | 1 | Chip select 1, active low |
| wss_n | output | 1 | Wait-sample strobe, active low |
| rdy | output | 1 | Cycle-complete pulse |

## Verification
The assertions check properties that must hold on every clock:
- the two selects are never low together;
- `rdy` lasts a single clock and releases both selects behind it;
- the strobe falls only inside `t4` of a region-0 cycle;
- an internal access never drives chip select 0;
- a cycle with no select finishes straight after `t4`.

Only the bench scenarios can show the timing that depends on data: the exact wait length taken from each count source, the zero and maximum counts, the effect of changing the range field, and that a second start pulse inside a cycle is ignored.

// File: rtl/wsg_pkg.sv
package wsg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_HOLD,
        ST_DONE
    } wsg_state_e;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_CS0,
        SEL_CS1
    } wsg_sel_e;
endpackage

// File: rtl/wsg_decode.sv
module wsg_decode
    import wsg_pkg::*;
#(
    parameter int RNG_W = 2
) (
    input  logic [RNG_W:0]   addr_top,
    input  logic             int_acc,
    input  logic [RNG_W-1:0] cs0_rng,
    input  logic [RNG_W-1:0] cs1_rng,
    output wsg_sel_e         sel
);
    logic hit0, hit1;

    assign hit0 = (addr_top == {1'b0, cs0_rng});
    assign hit1 = (addr_top == {1'b1, cs1_rng});

    always_comb begin
        if (hit0 && !int_acc)
            sel = SEL_CS0;
        else if (hit1)
            sel = SEL_CS1;
        else
            sel = SEL_NONE;
    end
endmodule

// File: rtl/wsg_src.sv
module wsg_src
    import wsg_pkg::*;
#(
    parameter int CNT_W = 3,
    parameter int WS1_W = 2
) (
    input  wsg_sel_e         sel,
    input  logic             cs0_ext,
    input  logic [CNT_W-1:0] wait_dat,
    input  logic [CNT_W-1:0] cs0_wait,
    input  logic [WS1_W-1:0] cs1_wait,
    output logic [CNT_W-1:0] count,
    output logic             count_zero
);
    logic [CNT_W-1:0] cs1_full;

    generate
        if (WS1_W < CNT_W) begin : g_widen
            assign cs1_full = {{(CNT_W-WS1_W){1'b0}}, cs1_wait};
        end else begin : g_trim
            assign cs1_full = cs1_wait[CNT_W-1:0];
        end
    endgenerate

    always_comb begin
        unique case (sel)
            SEL_CS0:  count = cs0_ext ? wait_dat : cs0_wait;
            SEL_CS1:  count = cs1_full;
            default:  count = '0;
        endcase
    end

    assign count_zero = (count == '0);
endmodule

// File: rtl/wsg_count.sv
module wsg_count #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             last
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (dec && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign last = (cnt == {{(CNT_W-1){1'b0}}, 1'b1});
endmodule

// File: rtl/wsg_fsm.sv
module wsg_fsm
    import wsg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     acc_start,
    input  logic     t4,
    input  logic     strobe_en,
    input  wsg_sel_e sel_in,
    input  logic     count_zero,
    input  logic     cnt_last,
    output wsg_sel_e sel_q,
    output logic     load,
    output logic     dec,
    output logic     cs0_n,
    output logic     cs1_n,
    output logic     wss_n,
    output logic     rdy,
    output logic     busy
);
    wsg_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            sel_q <= SEL_NONE;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && acc_start)
                sel_q <= sel_in;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (acc_start) state_nx = ST_ADDR;
            ST_ADDR: if (t4) state_nx = count_zero ? ST_DONE : ST_HOLD;
            ST_HOLD: if (cnt_last) state_nx = ST_DONE;
            ST_DONE: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        busy  = (state != ST_IDLE);
        cs0_n = !(busy && sel_q == SEL_CS0);
        cs1_n = !(busy && sel_q == SEL_CS1);
        load  = (state == ST_ADDR) && t4;
        dec   = (state == ST_HOLD);
        rdy   = (state == ST_DONE);
        wss_n = !((state == ST_ADDR) && t4 && strobe_en && sel_q == SEL_CS0);
    end
endmodule

// File: rtl/wsg_top.sv
module wsg_top
    import wsg_pkg::*;
#(
    parameter int RNG_W = 2,
    parameter int CNT_W = 3,
    parameter int WS1_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_start,
    input  logic [RNG_W:0]   addr_top,
    input  logic             int_acc,
    input  logic             t4,
    input  logic [CNT_W-1:0] wait_dat,
    input  logic [RNG_W-1:0] cs0_rng,
    input  logic [RNG_W-1:0] cs1_rng,
    input  logic             cs0_ext,
    input  logic [CNT_W-1:0] cs0_wait,
    input  logic [WS1_W-1:0] cs1_wait,
    input  logic             strobe_en,
    output logic             cs0_n,
    output logic             cs1_n,
    output logic             wss_n,
    output logic             rdy
);
    wsg_sel_e         sel_dec, sel_q;
    logic [CNT_W-1:0] count;
    logic             count_zero, cnt_last, load, dec, busy;

    wsg_decode #(.RNG_W(RNG_W)) u_dec (
        .addr_top (addr_top),
        .int_acc  (int_acc),
        .cs0_rng  (cs0_rng),
        .cs1_rng  (cs1_rng),
        .sel      (sel_dec)
    );

    wsg_src #(.CNT_W(CNT_W), .WS1_W(WS1_W)) u_src (
        .sel        (sel_q),
        .cs0_ext    (cs0_ext),
        .wait_dat   (wait_dat),
        .cs0_wait   (cs0_wait),
        .cs1_wait   (cs1_wait),
        .count      (count),
        .count_zero (count_zero)
    );

    wsg_count #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (count),
        .dec      (dec),
        .last     (cnt_last)
    );

    wsg_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_start  (acc_start),
        .t4         (t4),
        .strobe_en  (strobe_en),
        .sel_in     (sel_dec),
        .count_zero (count_zero),
        .cnt_last   (cnt_last),
        .sel_q      (sel_q),
        .load       (load),
        .dec        (dec),
        .cs0_n      (cs0_n),
        .cs1_n      (cs1_n),
        .wss_n      (wss_n),
        .rdy        (rdy),
        .busy       (busy)
    );
endmodule

// File: rtl/wsg_chk.sv
module wsg_chk (
    input logic clk,
    input logic rst_n,
    input logic acc_start,
    input logic int_acc,
    input logic t4,
    input logic cs0_n,
    input logic cs1_n,
    input logic wss_n,
    input logic rdy,
    input logic busy
);
    // R1
    one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs0_n || cs1_n);

    // R6
    rdy_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdy |=> !rdy);

    // R7
    release_after_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdy |=> (cs0_n && cs1_n));

    // R8
    strobe_in_t4_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wss_n |-> (t4 && !cs0_n));

    // R2
    internal_no_cs0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_start && int_acc && !busy) |=> cs0_n);

    // R9
    unselected_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (t4 && busy && !rdy && cs0_n && cs1_n) |=> rdy);
endmodule

bind wsg_top wsg_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_start (acc_start),
    .int_acc   (int_acc),
    .t4        (t4),
    .cs0_n     (cs0_n),
    .cs1_n     (cs1_n),
    .wss_n     (wss_n),
    .rdy       (rdy),
    .busy      (busy)
);

// File: tb/sim_wsg_top.sv
module sim_wsg_top;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_start = 1'b0;
    logic [2:0] addr_top = 3'b000;
    logic       int_acc = 1'b0;
    logic       t4 = 1'b0;
    logic [2:0] wait_dat = 3'b000;
    logic [1:0] cs0_rng = 2'b01;
    logic [1:0] cs1_rng = 2'b10;
    logic       cs0_ext = 1'b1;
    logic [2:0] cs0_wait = 3'd0;
    logic [1:0] cs1_wait = 2'd0;
    logic       strobe_en = 1'b1;
    logic       cs0_n, cs1_n, wss_n, rdy;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    typedef struct {
        bit c0;
        bit c1;
        bit strobe;
        int waits;
        int tag;
    } exp_t;

    exp_t exp_q[$];

    always #(CLK_P/2) clk = ~clk;

    wsg_top u0 (
        .clk(clk), .rst_n(rst_n), .acc_start(acc_start), .addr_top(addr_top),
        .int_acc(int_acc), .t4(t4), .wait_dat(wait_dat), .cs0_rng(cs0_rng),
        .cs1_rng(cs1_rng), .cs0_ext(cs0_ext), .cs0_wait(cs0_wait),
        .cs1_wait(cs1_wait), .strobe_en(strobe_en), .cs0_n(cs0_n),
        .cs1_n(cs1_n), .wss_n(wss_n), .rdy(rdy)
    );

    function automatic string tag_name(int t);
        case (t)
            3:  return "R3";
            4:  return "R4";
            5:  return "R5";
            9:  return "R9";
            10: return "R10";
            2:  return "R2";
            default: return "R6";
        endcase
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Driver: computes the expected outcome and runs one bus cycle.
    task automatic access(logic [2:0] a, bit intf, logic [2:0] d, bit poke, int tag);
        exp_t e;
        e.c0 = (a == {1'b0, cs0_rng}) && !intf;
        e.c1 = !e.c0 && (a == {1'b1, cs1_rng});
        e.waits = e.c0 ? int'(cs0_ext ? d : cs0_wait) : (e.c1 ? int'(cs1_wait) : 0);
        e.strobe = e.c0 && strobe_en;
        e.tag = tag;
        exp_q.push_back(e);
        @(posedge clk); #1;
        addr_top = a; int_acc = intf; acc_start = 1'b1;
        @(posedge clk); #1;
        acc_start = 1'b0; addr_top = ~a; int_acc = 1'b0;
        @(posedge clk); #1;
        @(posedge clk); #1;
        t4 = 1'b1; wait_dat = d;
        @(posedge clk); #1;
        t4 = 1'b0; wait_dat = ~d;
        if (poke) begin
            acc_start = 1'b1; addr_top = {1'b1, cs1_rng};
            @(posedge clk); #1;
            acc_start = 1'b0;
        end
        while (exp_q.size() != 0) @(posedge clk);
        #1;
        repeat (2) @(posedge clk);
        #1;
    endtask

    // Monitor: measures each cycle and compares it with the queue head.
    bit   tracking = 1'b0;
    bit   rel_pend = 1'b0;
    int   wcnt = 0;
    bit   seen_c0, seen_c1, seen_strobe;
    exp_t cur;

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (rel_pend) begin
                // R7
                check(cs0_n && cs1_n, "R7", {cs0_n, cs1_n}, 3);
                rel_pend = 1'b0;
            end
            if (!t4) begin
                // R8: strobe stays high outside T4
                check(wss_n, "R8", wss_n, 1);
            end
            if (t4 && !tracking && exp_q.size() != 0) begin
                tracking = 1'b1;
                wcnt = 0;
                seen_c0 = !cs0_n;
                seen_c1 = !cs1_n;
                seen_strobe = !wss_n;
            end else if (tracking) begin
                if (rdy) begin
                    cur = exp_q.pop_front();
                    // R1 / R2: which select drove the cycle
                    check(seen_c0 == cur.c0, cur.c0 ? "R1" : "R2", seen_c0, cur.c0);
                    check(seen_c1 == cur.c1, "R1", seen_c1, cur.c1);
                    // R8
                    check(seen_strobe == cur.strobe, "R8", seen_strobe, cur.strobe);
                    check(wcnt == cur.waits, tag_name(cur.tag), wcnt, cur.waits);
                    tracking = 1'b0;
                    rel_pend = 1'b1;
                end else begin
                    wcnt++;
                    // R10: select held through the wait
                    check(seen_c0 == !cs0_n && seen_c1 == !cs1_n, "R10",
                          {!cs0_n, !cs1_n}, {seen_c0, seen_c1});
                end
            end
        end
    end

    task automatic finish_run();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11
        check(cs0_n && cs1_n && wss_n && !rdy, "R11", {cs0_n, cs1_n, wss_n, rdy}, 4'b1110);
        rst_n = 1'b1;
        @(negedge clk);
        check(cs0_n && cs1_n && !rdy, "R11", {cs0_n, cs1_n, rdy}, 3'b110);

        // R3: external count, maximum and several values
        cs0_ext = 1'b1; strobe_en = 1'b1;
        access(3'b001, 1'b0, 3'b111, 1'b0, 3);
        access(3'b001, 1'b0, 3'b010, 1'b0, 3);
        access(3'b001, 1'b0, 3'b000, 1'b0, 3);
        // R4: internal count ignores the data lines
        cs0_ext = 1'b0; cs0_wait = 3'd5;
        access(3'b001, 1'b0, 3'b111, 1'b0, 4);
        cs0_wait = 3'd0;
        access(3'b001, 1'b0, 3'b110, 1'b0, 4);
        // R2: internal access in region 0
        cs0_ext = 1'b1;
        access(3'b001, 1'b1, 3'b111, 1'b0, 2);
        // R5: region-1 counts
        for (int k = 0; k < 4; k++) begin
            cs1_wait = 2'(k);
            access(3'b110, 1'b0, 3'b111, 1'b0, 5);
        end
        // R9: no region hit
        access(3'b100, 1'b0, 3'b111, 1'b0, 9);
        access(3'b000, 1'b0, 3'b101, 1'b0, 9);
        // R8: strobe disabled
        strobe_en = 1'b0;
        access(3'b001, 1'b0, 3'b011, 1'b0, 3);
        strobe_en = 1'b1;
        // R10: start pulse during the wait is ignored
        access(3'b001, 1'b0, 3'b100, 1'b1, 10);
        // R1: move region 0 and region 1
        cs0_rng = 2'b11; cs1_rng = 2'b00;
        access(3'b011, 1'b0, 3'b001, 1'b0, 3);
        cs1_wait = 2'd2;
        access(3'b100, 1'b0, 3'b111, 1'b0, 5);
        access(3'b001, 1'b0, 3'b111, 1'b0, 9);

        repeat (3) @(posedge clk);
        finish_run();
    end
endmodule